// File: doc/BRIEF.md
# MSI to Adapter Interrupt Bridge

This block turns message-signalled-interrupt data writes into adapter-interrupt indicator updates. Each write word holds a function number in its upper bits and a vector number in its low bits. The function number selects one of a small set of function slots. A slot holds an indicator bit-string base and offset, a summary bit base and offset, and an interrupt subclass.

For a known function, the block performs two atomic read-OR-write byte updates over a locked single-outstanding memory port. The first update sets the per-vector indicator bit. The second sets the function's summary bit. An I/O interrupt word goes out only when the summary byte was entirely zero before the update, so a burst of vectors costs one interrupt. A write that names no function produces an error event and touches no memory. A memory fault during an update produces a different error event. Reads of the notification port return all ones.

Top module: `msi_adapter_bridge`

## Requirements
- R1: The write word splits into a function number in bits [31:5] and a vector number in bits [4:0].
- R2: Lookup picks the lowest-numbered slot whose enable is set and whose function number equals the requested one. Disabled slots never match.
- R3: The indicator bit position is the slot's indicator offset plus the vector. The byte written is indicator base + position/8, the mask is 8'h80 >> (position mod 8), and every other bit of that byte keeps its value.
- R4: The summary bit is placed the same way from the summary base and summary offset, and it is updated after the indicator.
- R5: Each update reads the byte and then writes old|mask to the same address. The lock is held with every request, and a request is held with a stable address until acknowledged.
- R6: An interrupt is issued only when the old summary byte was 8'h00. The interrupt word carries the subclass in bits [31:27] and the adapter flag in bit 0, with all other bits zero.
- R7: An unknown function number raises an event with code 1, the function number, the write address, and a qualifier equal to the vector shifted left by 8. It makes no memory access and raises no interrupt.
- R8: A memory error raises an event with code 2 and zero function, address and qualifier fields, and abandons that byte's update. An indicator fault still proceeds to the summary update. A summary fault suppresses the interrupt.
- R9: A read request is answered one cycle later with data 32'hFFFFFFFF.
- R10: msi_ready is low while an update is in progress, and a write presented while msi_ready is low is ignored.
- R11: After reset msi_ready is high and mem_req, irq_valid and evt_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_wr_valid | input | 1 | Interrupt message write strobe |
| msi_wr_addr | input | ADDR_W | Address of the message write |
| msi_wr_data | input | DATA_W | Message data: function and vector |
| msi_ready | output | 1 | Block can accept a write |
| msi_rd_req | input | 1 | Read of the notification port |
| msi_rd_valid | output | 1 | Read answer strobe |
| msi_rd_data | output | DATA_W | Read answer data |
| slot_en | input | N_SLOT | Per-slot enable (non-zero handle) |
| slot_fid | input | N_SLOT*FID_W | Per-slot function number |
| slot_ind_base | input | N_SLOT*ADDR_W | Per-slot indicator byte base |
| slot_ind_off | input | N_SLOT*OFF_W | Per-slot indicator bit offset |
| slot_sum_base | input | N_SLOT*ADDR_W | Per-slot summary byte base |
| slot_sum_off | input | N_SLOT*OFF_W | Per-slot summary bit offset |
| slot_isc | input | N_SLOT*5 | Per-slot interrupt subclass |
| mem_req | output | 1 | Memory byte request |
| mem_lock | output | 1 | Locked-sequence indication |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 8 | Read byte |
| mem_err | input | 1 | Access failed |
| irq_valid | output | 1 | Interrupt word strobe |
| irq_word | output | 32 | Interrupt word |
| evt_valid | output | 1 | Error event strobe |
| evt_code | output | 4 | Event code |
| evt_fid | output | FID_W | Event function number |
| evt_addr | output | ADDR_W | Event address |
| evt_qual | output | 32 | Event qualifier |

## Verification
The writes hit every vector extreme (0 and 31) and offsets that cross byte boundaries. This separates correct bit placement from an off-by-one or a reversed mask. Indicator bytes pre-seeded with a pattern show whether the update ORs or overwrites.

Two functions share one summary byte, and the summary is later cleared and re-armed. Together these show whether interrupts follow the 0-to-1 rule rather than firing on every write. Duplicate function numbers on a disabled slot and on two enabled slots test the lookup priority. Faulting indicator and summary addresses, unknown functions, and writes offered while busy cover the error and ignore paths.

// File: rtl/msi_adapter_bridge.sv
module msi_adapter_bridge #(
  parameter int N_SLOT   = 8,
  parameter int VEC_W    = 5,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16,
  parameter int QUAL_LSB = 8,
  localparam int FID_W   = DATA_W - VEC_W,
  localparam int ISC_W   = 5,
  localparam int IDX_W   = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int POS_W   = OFF_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      msi_wr_valid,
  input  logic [ADDR_W-1:0]         msi_wr_addr,
  input  logic [DATA_W-1:0]         msi_wr_data,
  output logic                      msi_ready,
  input  logic                      msi_rd_req,
  output logic                      msi_rd_valid,
  output logic [DATA_W-1:0]         msi_rd_data,
  input  logic [N_SLOT-1:0]         slot_en,
  input  logic [N_SLOT*FID_W-1:0]   slot_fid,
  input  logic [N_SLOT*ADDR_W-1:0]  slot_ind_base,
  input  logic [N_SLOT*OFF_W-1:0]   slot_ind_off,
  input  logic [N_SLOT*ADDR_W-1:0]  slot_sum_base,
  input  logic [N_SLOT*OFF_W-1:0]   slot_sum_off,
  input  logic [N_SLOT*ISC_W-1:0]   slot_isc,
  output logic                      mem_req,
  output logic                      mem_lock,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [7:0]                mem_wdata,
  input  logic                      mem_ack,
  input  logic [7:0]                mem_rdata,
  input  logic                      mem_err,
  output logic                      irq_valid,
  output logic [31:0]               irq_word,
  output logic                      evt_valid,
  output logic [3:0]                evt_code,
  output logic [FID_W-1:0]          evt_fid,
  output logic [ADDR_W-1:0]         evt_addr,
  output logic [31:0]               evt_qual
);
  localparam logic [3:0] EV_NO_TARGET = 4'd1;
  localparam logic [3:0] EV_IND_FAULT = 4'd2;

  typedef enum logic [2:0] {S_IDLE, S_IND_RD, S_IND_WR, S_SUM_RD, S_SUM_WR} st_t;
  st_t state;

  wire [FID_W-1:0] req_fid = msi_wr_data[DATA_W-1:VEC_W];
  wire [VEC_W-1:0] req_vec = msi_wr_data[VEC_W-1:0];
  wire             accept  = msi_wr_valid && (state == S_IDLE);

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (slot_en[i] && slot_fid[i*FID_W +: FID_W] == req_fid) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] ind_base_q, sum_base_q;
  logic [OFF_W-1:0]  ind_off_q, sum_off_q;
  logic [ISC_W-1:0]  isc_q;
  logic [7:0]        old_q;

  wire [POS_W-1:0]  ind_pos  = POS_W'(ind_off_q) + POS_W'(vec_q);
  wire [POS_W-1:0]  sum_pos  = POS_W'(sum_off_q);
  wire [ADDR_W-1:0] ind_addr = ind_base_q + ADDR_W'(ind_pos >> 3);
  wire [ADDR_W-1:0] sum_addr = sum_base_q + ADDR_W'(sum_pos >> 3);
  wire [7:0]        ind_mask = 8'h80 >> ind_pos[2:0];
  wire [7:0]        sum_mask = 8'h80 >> sum_pos[2:0];
  wire              on_ind   = (state == S_IND_RD) || (state == S_IND_WR);
  wire [7:0]        cur_mask = on_ind ? ind_mask : sum_mask;

  assign msi_ready = (state == S_IDLE);
  assign mem_req   = (state != S_IDLE);
  assign mem_lock  = mem_req;
  assign mem_we    = (state == S_IND_WR) || (state == S_SUM_WR);
  assign mem_addr  = on_ind ? ind_addr : sum_addr;
  assign mem_wdata = old_q | cur_mask;
  assign msi_rd_data = msi_rd_valid ? {DATA_W{1'b1}} : '0;

  wire done = mem_req && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      vec_q        <= '0;
      ind_base_q   <= '0;
      sum_base_q   <= '0;
      ind_off_q    <= '0;
      sum_off_q    <= '0;
      isc_q        <= '0;
      old_q        <= '0;
      msi_rd_valid <= 1'b0;
      irq_valid    <= 1'b0;
      irq_word     <= '0;
      evt_valid    <= 1'b0;
      evt_code     <= '0;
      evt_fid      <= '0;
      evt_addr     <= '0;
      evt_qual     <= '0;
    end else begin
      msi_rd_valid <= msi_rd_req;
      irq_valid    <= 1'b0;
      evt_valid    <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          if (hit) begin
            vec_q      <= req_vec;
            ind_base_q <= slot_ind_base[hit_idx*ADDR_W +: ADDR_W];
            ind_off_q  <= slot_ind_off[hit_idx*OFF_W +: OFF_W];
            sum_base_q <= slot_sum_base[hit_idx*ADDR_W +: ADDR_W];
            sum_off_q  <= slot_sum_off[hit_idx*OFF_W +: OFF_W];
            isc_q      <= slot_isc[hit_idx*ISC_W +: ISC_W];
            state      <= S_IND_RD;
          end else begin
            evt_valid <= 1'b1;
            evt_code  <= EV_NO_TARGET;
            evt_fid   <= req_fid;
            evt_addr  <= msi_wr_addr;
            evt_qual  <= 32'(req_vec) << QUAL_LSB;
          end
        end
        S_IND_RD, S_SUM_RD: if (done) begin
          old_q <= mem_rdata;
          if (mem_err) begin
            evt_valid <= 1'b1;
            evt_code  <= EV_IND_FAULT;
            evt_fid   <= '0;
            evt_addr  <= '0;
            evt_qual  <= '0;
            state     <= (state == S_IND_RD) ? S_SUM_RD : S_IDLE;
          end else begin
            state <= (state == S_IND_RD) ? S_IND_WR : S_SUM_WR;
          end
        end
        S_IND_WR, S_SUM_WR: if (done) begin
          if (mem_err) begin
            evt_valid <= 1'b1;
            evt_code  <= EV_IND_FAULT;
            evt_fid   <= '0;
            evt_addr  <= '0;
            evt_qual  <= '0;
          end else if (state == S_SUM_WR && old_q == 8'h00) begin
            irq_valid <= 1'b1;
            irq_word  <= {isc_q, 26'd0, 1'b1};
          end
          state <= (state == S_IND_WR) ? S_SUM_RD : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_adapter_bridge_chk.sv
module msi_adapter_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msi_ready,
  input logic              msi_rd_req,
  input logic              msi_rd_valid,
  input logic [DATA_W-1:0] msi_rd_data,
  input logic              mem_req,
  input logic              mem_lock,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              irq_valid,
  input logic [31:0]       irq_word,
  input logic              evt_valid
);
  a_r5_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock);
  a_r5_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we && !mem_err) |=>
      (mem_req && mem_we && mem_addr == $past(mem_addr)));
  a_r6_irq_format: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_word[0] && irq_word[26:1] == 26'd0));
  a_r9_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    msi_rd_req |=> (msi_rd_valid && msi_rd_data == {DATA_W{1'b1}}));
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !msi_ready);
  a_r8_single_output: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && evt_valid));
endmodule

bind msi_adapter_bridge msi_adapter_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .msi_ready(msi_ready), .msi_rd_req(msi_rd_req),
  .msi_rd_valid(msi_rd_valid), .msi_rd_data(msi_rd_data), .mem_req(mem_req),
  .mem_lock(mem_lock), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .mem_err(mem_err), .irq_valid(irq_valid), .irq_word(irq_word), .evt_valid(evt_valid)
);

// File: tb/test_msi_adapter_bridge.sv
module test_msi_adapter_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8, VW = 5, DW = 32, AW = 32, OW = 16, FW = DW - VW, IW = 5;
  localparam int FAULT_LO = 32'h8000, FAULT_HI = 32'h80FF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic msi_wr_valid = 0, msi_rd_req = 0;
  logic [AW-1:0] msi_wr_addr = '0;
  logic [DW-1:0] msi_wr_data = '0;
  logic msi_ready, msi_rd_valid;
  logic [DW-1:0] msi_rd_data;
  logic [N-1:0] slot_en = '0;
  logic [N*FW-1:0] slot_fid = '0;
  logic [N*AW-1:0] slot_ind_base = '0, slot_sum_base = '0;
  logic [N*OW-1:0] slot_ind_off = '0, slot_sum_off = '0;
  logic [N*IW-1:0] slot_isc = '0;
  logic mem_req, mem_lock, mem_we, mem_ack = 0, mem_err = 0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 0;
  logic irq_valid, evt_valid;
  logic [31:0] irq_word, evt_qual;
  logic [3:0] evt_code;
  logic [FW-1:0] evt_fid;
  logic [AW-1:0] evt_addr;

  msi_adapter_bridge i_msi_adapter_bridge (.*);

  int checks = 0, fails = 0;
  logic [7:0] dut_mem [int];
  logic [7:0] ref_mem [int];
  logic [103:0] evt_q[$];
  logic [31:0] irq_q[$];
  int s_fid[N], s_ib[N], s_io[N], s_sb[N], s_so[N], s_isc[N];
  bit s_en[N];

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_slot(int i, bit en, int fid, int ib, int io, int sb, int so, int isc);
    s_en[i] = en; s_fid[i] = fid; s_ib[i] = ib; s_io[i] = io; s_sb[i] = sb; s_so[i] = so; s_isc[i] = isc;
    slot_en[i] = en;
    slot_fid[i*FW +: FW] = FW'(fid);
    slot_ind_base[i*AW +: AW] = AW'(ib);
    slot_ind_off[i*OW +: OW] = OW'(io);
    slot_sum_base[i*AW +: AW] = AW'(sb);
    slot_sum_off[i*OW +: OW] = OW'(so);
    slot_isc[i*IW +: IW] = IW'(isc);
  endtask

  function automatic bit faulty(int a);
    return a >= FAULT_LO && a <= FAULT_HI;
  endfunction

  task automatic ref_or(int a, logic [7:0] m, output bit ok, output logic [7:0] old);
    ok = !faulty(a);
    old = ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    if (ok) ref_mem[a] = old | m;
    else evt_q.push_back({8'd2, 32'd0, 32'd0, 32'd0});
  endtask

  // Reference: R1 split, R2 lookup, R3/R4 bit placement, R6 coalescing, R7/R8 events
  task automatic ref_issue(int addr, int data);
    int fid, vec, hit, pos;
    bit ok;
    logic [7:0] old;
    fid = data >>> VW; vec = data & ((1 << VW) - 1); hit = -1;
    for (int i = 0; i < N; i++) if (hit < 0 && s_en[i] && s_fid[i] == fid) hit = i;
    if (hit < 0) begin
      evt_q.push_back({8'd1, 32'(fid), 32'(addr), 32'(vec << 8)});
      return;
    end
    pos = s_io[hit] + vec;
    ref_or(s_ib[hit] + pos / 8, 8'h80 >> (pos % 8), ok, old);
    pos = s_so[hit];
    ref_or(s_sb[hit] + pos / 8, 8'h80 >> (pos % 8), ok, old);
    if (ok && old == 8'h00) irq_q.push_back({5'(s_isc[hit]), 26'd0, 1'b1});
  endtask

  task automatic issue(int addr, int fid, int vec, bit busy_poke);
    int data;
    data = (fid << VW) | vec;
    while (!msi_ready) @(negedge clk);
    msi_wr_valid = 1; msi_wr_addr = AW'(addr); msi_wr_data = DW'(data);
    ref_issue(addr, data);
    @(negedge clk);
    msi_wr_valid = 0;
    if (busy_poke) begin
      check(msi_ready == 0, "R10", "ready while busy", 128'(msi_ready), 0);
      msi_wr_valid = 1; msi_wr_data = DW'((4 << VW) | 1);
      @(negedge clk);
      msi_wr_valid = 0;
    end
    while (!msi_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read();
    msi_rd_req = 1;
    @(negedge clk);
    msi_rd_req = 0;
    check(msi_rd_valid && msi_rd_data == 32'hFFFFFFFF, "R9", "read answer",
          128'({msi_rd_valid, msi_rd_data}), 128'({1'b1, 32'hFFFFFFFF}));
    @(negedge clk);
    check(msi_rd_valid == 0, "R9", "read strobe single", 128'(msi_rd_valid), 0);
  endtask

  task automatic poke_mem(int a, logic [7:0] v);
    dut_mem[a] = v; ref_mem[a] = v;
  endtask

  // Memory responder: variable latency, fault window
  initial begin : responder
    int wcnt, lat, a;
    wcnt = 0; lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; mem_err = 0;
      end else if (rst_n && mem_req) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0; lat = (lat + 1) % 3;
          a = int'(mem_addr);
          if (faulty(a)) begin mem_err = 1; mem_rdata = 8'h00; end
          else begin
            mem_err = 0;
            if (mem_we) dut_mem[a] = mem_wdata;
            mem_rdata = dut_mem.exists(a) ? dut_mem[a] : 8'h00;
          end
          mem_ack = 1;
        end
      end
    end
  end

  // Per-cycle comparison against the reference queues
  initial begin : monitor
    logic [103:0] got, exp;
    forever begin
      @(negedge clk);
      if (rst_n && evt_valid) begin
        got = {4'd0, evt_code, 5'd0, evt_fid, evt_addr, evt_qual};
        if (evt_q.size() == 0) check(0, "R7/R8", "unexpected event", 128'(got), 0);
        else begin
          exp = evt_q.pop_front();
          check(got == exp, exp[103:96] == 8'd1 ? "R7" : "R8", "event", 128'(got), 128'(exp));
        end
      end
      if (rst_n && irq_valid) begin
        if (irq_q.size() == 0) check(0, "R6", "unexpected interrupt", 128'(irq_word), 0);
        else begin
          exp = 104'(irq_q.pop_front());
          check(irq_word == exp[31:0], "R6", "interrupt word", 128'(irq_word), 128'(exp));
        end
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    summary();
  end

  initial begin : main
    set_slot(0, 1, 5,  32'h1000, 0,   32'h2000, 3,  6);
    set_slot(1, 0, 9,  32'h1200, 0,   32'h2200, 0,  7);
    set_slot(2, 1, 3,  32'h1500, 250, 32'h2500, 17, 1);
    set_slot(3, 1, 9,  32'h1100, 13,  32'h2000, 3,  2);
    set_slot(4, 1, 12, 32'h1300, 7,   32'h2300, 0,  4);
    set_slot(5, 1, 12, 32'h1400, 0,   32'h2400, 0,  8);
    set_slot(6, 1, 15, 32'h8000, 0,   32'h2600, 9,  31);
    set_slot(7, 1, 20, 32'h1700, 2,   32'h8010, 0,  3);
    poke_mem(32'h1500 + 31, 8'h5A);
    poke_mem(32'h1500 + 35, 8'h5A);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(msi_ready == 1, "R11", "ready after reset", 128'(msi_ready), 1);
    check(mem_req == 0, "R11", "mem_req after reset", 128'(mem_req), 0);
    check(irq_valid == 0 && evt_valid == 0, "R11", "strobes after reset",
          128'({irq_valid, evt_valid}), 0);

    issue(32'hF000, 5, 0, 1);    // R1 R3 R6 R10: first vector arms summary, ignored poke
    issue(32'hF000, 5, 31, 0);   // R3 byte 3 mask 01, summary already set: no irq
    issue(32'hF000, 9, 2, 0);    // R2 disabled slot skipped, R4 shared summary
    issue(32'hF000, 12, 9, 0);   // R2 lowest enabled slot wins
    issue(32'hF004, 100, 17, 0); // R7 unknown function
    issue(32'hF008, 4, 31, 0);   // R7 function of the ignored poke is also unknown
    issue(32'hF000, 3, 0, 0);    // R3 offset 250 across bytes, OR with seeded 0x5A
    issue(32'hF000, 3, 31, 0);   // R3 position 281
    issue(32'hF000, 15, 6, 0);   // R8 indicator fault, summary still updated
    issue(32'hF000, 20, 1, 0);   // R8 summary fault suppresses interrupt
    issue(32'hF000, 5, 0, 0);    // repeat: no change, no irq
    poke_mem(32'h2000, 8'h00);   // R6 re-arm summary
    issue(32'hF000, 9, 30, 0);
    issue(32'hF000, 12, 0, 1);
    do_read();
    do_read();

    repeat (4) @(negedge clk);
    check(evt_q.size() == 0, "R7/R8", "events outstanding", 128'(evt_q.size()), 0);
    check(irq_q.size() == 0, "R6", "interrupts outstanding", 128'(irq_q.size()), 0);
    foreach (ref_mem[a])
      check(dut_mem.exists(a) && dut_mem[a] == ref_mem[a], "R3/R4", $sformatf("byte %0h", a),
            128'(dut_mem.exists(a) ? dut_mem[a] : 8'h00), 128'(ref_mem[a]));
    foreach (dut_mem[a])
      check(ref_mem.exists(a), "R5", $sformatf("stray write %0h", a), 128'(dut_mem[a]), 0);
    summary();
  end
endmodule